// File: doc/BRIEF.md
# Dual-Lane Sampling Converter Host Controller

This block is the host-side master for a two-core converter that samples both cores at the same instant and returns their results over one shared serial clock and select line, with one data line per core. From a system clock it makes the active-low select and a serial clock whose half period is programmable. The two data lines are captured together. The framing zero and the trailing padding are removed, and each frame yields a pair of 12-bit results. The results come with a one-cycle strobe, a tag that names the input pair sampled, and a flag that marks data which must be discarded.

A simple command port accepts three operations: convert, power-down and wake. The controller shapes each frame to suit the operation. A convert or wake frame runs in full, 16 serial cycles or 14 in short mode. A power-down frame ends the select after the fourth falling clock edge. The controller tracks whether the converter is asleep. A frame issued while the converter sleeps therefore acts as the dummy wake-up frame, and its data is flagged. After every frame, the select is held high for a programmable quiet time before the next frame may start.

Top module: `dual_adc_host`

## Requirements
- R1: In reset and immediately after it, cs_n=1, sclk=1, chsel=0, busy=0 and res_valid=0.
- R2: Each sclk half period lasts cfg_div+1 clk cycles, and this includes the setup half between the fall of cs_n and the first falling sclk edge. sclk is high whenever cs_n is high.
- R3: cs_n falls on the cycle after a command is accepted. A convert or wake frame then gives 16 falling sclk edges, or 14 when cfg_short=1. cs_n rises at the end of the high half that follows the last rising edge.
- R4: Both lanes are sampled at each rising sclk edge. The lane bit of serial cycle 1 is the framing zero, and cycles 2 to 13 carry the 12 result bits MSB first. Those 12 bits appear on res_a and res_b.
- R5: res_valid is a single-cycle pulse raised on the same clk edge as cs_n. res_a, res_b, res_chan and res_invalid are valid while it is high.
- R6: chsel takes the command's cmd_sel value (0 = input pair 1, 1 = input pair 2) at the second rising sclk edge of that command's frame. It changes at no other time. res_chan reports the chsel level at the fall of cs_n, which is the pair actually sampled.
- R7: cmd_op=2'b01 (power-down) ends the frame after exactly 4 falling sclk edges and reports res_invalid=1. The converter is then taken to be asleep.
- R8: cmd_op=2'b10 (wake) runs a full-length frame and reports res_invalid=1. The following convert is reported valid.
- R9: A convert (cmd_op=2'b00 or 2'b11) started while the converter is asleep, which includes the state after reset, reports res_invalid=1 and wakes it. A convert started while awake reports res_invalid=0.
- R10: busy is high from the cycle after acceptance until the quiet time ends. A command held on cmd_valid while busy waits and starts only after busy falls.
- R11: cs_n stays high at least 2*max(cfg_quiet,1)*(cfg_div+1) clk cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | sclk half period minus one, in clk cycles |
| cfg_quiet | input | 4 | Quiet time in sclk periods (0 is treated as 1) |
| cfg_short | input | 1 | 14-cycle frame mode |
| cmd_valid | input | 1 | Command request, accepted when busy is low |
| cmd_op | input | 2 | 00/11 convert, 01 power-down, 10 wake |
| cmd_sel | input | 1 | Input pair to drive on chsel |
| busy | output | 1 | Frame or quiet time in progress |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock, idle high |
| chsel | output | 1 | Input pair select |
| sdo_a | input | 1 | Data lane of core A |
| sdo_b | input | 1 | Data lane of core B |
| res_valid | output | 1 | Result strobe |
| res_a | output | 12 | Core A result |
| res_b | output | 12 | Core B result |
| res_chan | output | 1 | Pair sampled by this frame |
| res_invalid | output | 1 | Result must be discarded |

## Verification
The bench sweeps divider, quiet time and frame length against a behavioural converter. That model goes to sleep when cs_n rises after 2 to 9 falling edges and wakes on a frame of 10 or more. A controller that extracts the wrong bit field would report results shifted by one bit. One that ends power-down frames at the wrong edge count would leave the model awake, or asleep, against the expected state, and the result flags would then disagree. Two further errors are watched for: chsel moving outside the second rising edge, which would corrupt the sampled pair tag, and a held command starting during the quiet time, which would fail the minimum cs_n high time.

// File: rtl/dual_adc_host.sv
module dual_adc_host #(
  parameter int DATA_W    = 12,
  parameter int DIV_W     = 8,
  parameter int QUIET_W   = 4,
  parameter int FULL_CYC  = 16,
  parameter int SHORT_CYC = 14,
  parameter int PD_CYC    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [QUIET_W-1:0] cfg_quiet,
  input  logic               cfg_short,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_sel,
  output logic               busy,
  output logic               cs_n,
  output logic               sclk,
  output logic               chsel,
  input  logic               sdo_a,
  input  logic               sdo_b,
  output logic               res_valid,
  output logic [DATA_W-1:0]  res_a,
  output logic [DATA_W-1:0]  res_b,
  output logic               res_chan,
  output logic               res_invalid
);
  localparam int HW = $clog2(2*FULL_CYC + 1);
  localparam int QW = QUIET_W + 1;
  localparam logic [1:0] OP_PD = 2'b01;
  localparam logic [1:0] OP_WAKE = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_QUIET} st_t;
  st_t st;

  logic [DIV_W-1:0]   div_q, hcnt;
  logic [QUIET_W-1:0] q_q;
  logic [HW-1:0]      half, last_half;
  logic [QW-1:0]      qleft, q_halves;
  logic [1:0]         op_q;
  logic               short_q, sel_q, chan_q, asleep;
  logic [FULL_CYC-1:0] sh_a, sh_b;

  wire half_end = (hcnt == div_q);
  wire is_pd    = (op_q == OP_PD);
  wire is_conv  = (op_q != OP_PD) && (op_q != OP_WAKE);

  assign busy = (st != S_IDLE);
  assign q_halves = (q_q == '0) ? QW'(2) : {q_q, 1'b0};

  always_comb begin
    if (is_pd)        last_half = HW'(2*PD_CYC);
    else if (short_q) last_half = HW'(2*SHORT_CYC);
    else              last_half = HW'(2*FULL_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cs_n <= 1'b1;
      sclk <= 1'b1;
      chsel <= 1'b0;
      res_valid <= 1'b0;
      res_a <= '0;
      res_b <= '0;
      res_chan <= 1'b0;
      res_invalid <= 1'b0;
      asleep <= 1'b1;
      hcnt <= '0;
      half <= '0;
      qleft <= '0;
      div_q <= '0;
      q_q <= '0;
      op_q <= '0;
      short_q <= 1'b0;
      sel_q <= 1'b0;
      chan_q <= 1'b0;
      sh_a <= '0;
      sh_b <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          st <= S_RUN;
          cs_n <= 1'b0;
          hcnt <= '0;
          half <= '0;
          div_q <= cfg_div;
          q_q <= cfg_quiet;
          op_q <= cmd_op;
          short_q <= cfg_short;
          sel_q <= cmd_sel;
          chan_q <= chsel;
          sh_a <= '0;
          sh_b <= '0;
        end
        S_RUN: if (!half_end) begin
          hcnt <= hcnt + 1'b1;
        end else begin
          hcnt <= '0;
          if (half == last_half) begin
            cs_n <= 1'b1;
            st <= S_QUIET;
            qleft <= q_halves;
            res_valid <= 1'b1;
            res_chan <= chan_q;
            res_invalid <= !is_conv || asleep;
            res_a <= short_q ? sh_a[SHORT_CYC-2 -: DATA_W] : sh_a[FULL_CYC-2 -: DATA_W];
            res_b <= short_q ? sh_b[SHORT_CYC-2 -: DATA_W] : sh_b[FULL_CYC-2 -: DATA_W];
            asleep <= is_pd;
          end else begin
            half <= half + 1'b1;
            sclk <= ~sclk;
            if (half[0]) begin
              sh_a <= {sh_a[FULL_CYC-2:0], sdo_a};
              sh_b <= {sh_b[FULL_CYC-2:0], sdo_b};
            end
            if (half == HW'(3)) chsel <= sel_q;
          end
        end
        S_QUIET: if (!half_end) begin
          hcnt <= hcnt + 1'b1;
        end else begin
          hcnt <= '0;
          if (qleft == QW'(1)) st <= S_IDLE;
          else qleft <= qleft - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_adc_host_chk.sv
module dual_adc_host_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic chsel,
  input logic busy,
  input logic cmd_valid,
  input logic res_valid
);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  assert_chsel_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chsel) |-> (!cs_n && $rose(sclk)));

  assert_strobe_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(cs_n));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_start_accepted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(cmd_valid && !busy));

  assert_idle_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
endmodule

bind dual_adc_host dual_adc_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .chsel(chsel),
  .busy(busy), .cmd_valid(cmd_valid), .res_valid(res_valid)
);

// File: tb/dual_adc_host_test.sv
`timescale 1ns/1ps
module dual_adc_host_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic [3:0] cfg_quiet = 4'd0;
  logic cfg_short = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_sel = 1'b0;
  logic busy, cs_n, sclk, chsel, sdo_a, sdo_b;
  logic res_valid, res_chan, res_invalid;
  logic [11:0] res_a, res_b;

  always #2 clk = ~clk;

  dual_adc_host uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_quiet(cfg_quiet),
    .cfg_short(cfg_short), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .busy(busy), .cs_n(cs_n), .sclk(sclk), .chsel(chsel),
    .sdo_a(sdo_a), .sdo_b(sdo_b), .res_valid(res_valid), .res_a(res_a),
    .res_b(res_b), .res_chan(res_chan), .res_invalid(res_invalid)
  );

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      wrap_up();
    end
  end

  function automatic logic [11:0] fa(input int n, input int c);
    return 12'((n*53 + c*2048 + 7) & 4095);
  endfunction
  function automatic logic [11:0] fb(input int n, input int c);
    return 12'((n*91 + c*1024 + 300) & 4095);
  endfunction

  // converter model
  logic m_cs = 1'b1, m_sclk = 1'b1, m_asleep = 1'b1;
  int mfe = 0;
  int mfr = 0;
  logic [15:0] wa = '0, wb = '0;
  assign sdo_a = (mfe >= 1 && mfe <= 16) ? wa[16-mfe] : 1'b0;
  assign sdo_b = (mfe >= 1 && mfe <= 16) ? wb[16-mfe] : 1'b0;

  always @(cs_n or sclk) begin
    if (cs_n !== m_cs) begin
      if (cs_n === 1'b0) begin
        mfr++;
        mfe = 0;
        if (m_asleep) begin
          wa = 16'h7FF8;
          wb = 16'h7FF8;
        end else begin
          wa = {1'b0, fa(mfr, int'(chsel)), 3'b000};
          wb = {1'b0, fb(mfr, int'(chsel)), 3'b000};
        end
      end else if (m_cs === 1'b0) begin
        if (mfe >= 10) m_asleep = 1'b0;
        else if (mfe >= 2) m_asleep = 1'b1;
        mfe = 0;
      end
      m_cs = cs_n;
    end else if (sclk !== m_sclk) begin
      if (sclk === 1'b0 && cs_n === 1'b0) mfe++;
    end
    m_sclk = sclk;
  end

  // timing monitor
  int exp_falls = 16;
  int mon_div = 0, mon_q = 1;
  int cnt = 0, hi_cnt = 0, falls = 0, rises = 0;
  bit per_ok = 1, seen = 0;
  logic p_cs = 1'b1, p_sclk = 1'b1, p_ch = 1'b0;

  always @(negedge clk) if (rst_n) begin
    cnt++;
    if (p_cs && !cs_n) begin
      if (seen) chk(hi_cnt >= 2*mon_q*(mon_div+1), "R11", "quiet cycles", hi_cnt, 2*mon_q*(mon_div+1));
      chk(sclk == 1'b1, "R2", "sclk at frame start", int'(sclk), 1);
      seen = 1;
      mon_div = int'(cfg_div);
      mon_q = (cfg_quiet == 0) ? 1 : int'(cfg_quiet);
      falls = 0; rises = 0; per_ok = 1; cnt = 0;
    end else if (!cs_n && sclk != p_sclk) begin
      if (cnt != mon_div + 1) per_ok = 0;
      cnt = 0;
      if (!sclk) falls++; else rises++;
    end
    if (cs_n && !sclk) chk(0, "R2", "sclk low while deselected", 0, 1);
    if (chsel != p_ch) chk(!cs_n && rises == 2, "R6", "chsel change at rise", rises, 2);
    if (!p_cs && cs_n) begin
      chk(falls == exp_falls, "R3", "falling edges", falls, exp_falls);
      chk(per_ok, "R2", "half period", int'(per_ok), 1);
      hi_cnt = 0;
    end
    if (cs_n) hi_cnt++;
    p_cs = cs_n; p_sclk = sclk; p_ch = chsel;
  end

  bit dev_asleep = 1;
  bit exp_chsel = 0;

  task automatic wait_res();
    @(negedge clk);
    while (!res_valid) @(negedge clk);
  endtask

  task automatic check_res(input logic [1:0] op, input string req);
    bit exp_inv;
    exp_inv = (op == 2'b01) || (op == 2'b10) || dev_asleep;
    chk(res_invalid == exp_inv, req, "invalid flag", int'(res_invalid), int'(exp_inv));
    chk(res_chan == exp_chsel, "R6", "channel tag", int'(res_chan), int'(exp_chsel));
    if (!exp_inv) begin
      chk(res_a == fa(mfr, int'(exp_chsel)), "R4", "lane A", int'(res_a), int'(fa(mfr, int'(exp_chsel))));
      chk(res_b == fb(mfr, int'(exp_chsel)), "R4", "lane B", int'(res_b), int'(fb(mfr, int'(exp_chsel))));
    end
    @(negedge clk);
    chk(!res_valid && cs_n, "R5", "strobe width", int'(res_valid), 0);
    dev_asleep = (op == 2'b01);
  endtask

  task automatic do_frame(input logic [1:0] op, input bit sel);
    string req;
    exp_falls = (op == 2'b01) ? 4 : (cfg_short ? 14 : 16);
    req = (op == 2'b01) ? "R7" : (op == 2'b10) ? "R8" : "R9";
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel;
    @(negedge clk);
    chk(!cs_n && busy, "R3", "select after accept", int'(cs_n), 0);
    cmd_valid = 1'b0;
    wait_res();
    check_res(op, req);
    exp_chsel = sel;
  endtask

  initial begin
    logic [1:0] ops [7] = '{2'b10, 2'b00, 2'b11, 2'b00, 2'b01, 2'b00, 2'b00};
    bit sels [7] = '{0, 1, 0, 1, 0, 1, 0};
    int qs [2] = '{0, 2};
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !chsel && !busy && !res_valid, "R1", "reset state", int'(cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && sclk && !chsel && !busy && !res_valid, "R1", "after reset", int'(busy), 0);
    do_frame(2'b00, 0);
    for (int d = 0; d < 3; d++)
      for (int s = 0; s < 2; s++)
        for (int qi = 0; qi < 2; qi++) begin
          @(negedge clk);
          while (busy) @(negedge clk);
          cfg_div = 8'(d); cfg_short = s[0]; cfg_quiet = 4'(qs[qi]);
          for (int k = 0; k < 7; k++) do_frame(ops[k], sels[k]);
        end
    // held request: a second command waits through the quiet time
    exp_falls = 16;
    cfg_short = 1'b0; cfg_div = 8'd1; cfg_quiet = 4'd3;
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_sel = exp_chsel;
    wait_res();
    check_res(2'b00, "R10");
    chk(busy && cs_n, "R10", "held during quiet", int'(cs_n), 1);
    while (cs_n) @(negedge clk);
    cmd_valid = 1'b0;
    wait_res();
    check_res(2'b00, "R10");
    repeat (40) @(negedge clk);
    wrap_up();
  end
endmodule